// File: doc/BRIEF.md
# Shared Cache Control Register with Idle-Retention Timer

This block holds one 32-bit control and status word for a shared second-level cache. It also contains an idle-timeout engine that asks the RAM power logic to enter low-power retention. A register port reads and writes the word. Each access carries the requester's privilege level, its security state and two enable bits from higher privilege levels. Together these decide whether a write is accepted. A write that is refused changes nothing, and the block flags it with a one-cycle fault output one cycle later.

The word holds two sticky error flags and a 3-bit idle-threshold code:

- **Bit 30** is set by a pulse that reports an uncorrectable ECC error in the cache RAM.
- **Bit 29** is set by a pulse that reports an error on the external bus.
- **Bits 2:0** hold the threshold code.

Software clears a flag by writing 0 to its bit. Writing 1 to a flag bit has no effect.

The idle engine counts system-timer tick pulses while the cache reports idle. It raises the retention request once the count reaches the threshold that the code selects. It drops the request as soon as the cache becomes busy again.

The engine is a three-state machine:

- **RS_BUSY**: the cache is active and the counter is zero.
- **RS_WAIT**: the cache is idle and ticks are being counted.
- **RS_RETAIN**: the request is raised.

Its transitions are:

- **BUSY→WAIT** when idle rises.
- **WAIT→RETAIN** when the next count reaches the threshold and the code is non-zero.
- **RETAIN→WAIT** when the code becomes 000 or the next count falls below a newly written threshold.
- **WAIT→BUSY** and **RETAIN→BUSY** whenever idle is low.

Top module: `cache_ctl_top`

## Requirements
- R1: After reset the word reads 0x00000000, and both ret_req and acc_fault are 0.
- R2: Bit 31 and bits 28:3 always read 0, even after a write of all ones.
- R3: Bit 30 (RAM ECC flag) is set by a one-cycle ram_ecc_err pulse and then stays 1. An accepted write with bit 30 = 0 clears it. An accepted write with bit 30 = 1 leaves it unchanged.
- R4: Bit 29 (bus error flag) is set by a bus_err pulse and follows the same sticky, write-0-to-clear rule as R3.
- R5: If a set pulse and a clearing write reach the same flag in the same cycle, the flag ends up 1.
- R6: Bits 2:0 read back the last accepted written value. A new code takes effect without any reset.
- R7: At privilege 0 (req_priv = 2'd0), reads return 0 and writes are dropped.
- R8: At privilege 1, a write is accepted only when el3_en = 1 and either el2_en = 1 or req_ns = 0. Reads at privilege 1 are always allowed.
- R9: At privilege 2 and 3, reads and writes are always accepted.
- R10: A refused write leaves every bit unchanged and raises acc_fault for exactly the cycle that follows the write cycle. Accepted writes and reads never raise acc_fault.
- R11: While cache_idle is high, each timer_tick pulse adds 1 to the idle count. When cache_idle is low, the count clears. ret_req goes high in the cycle after the tick that brings the count to the threshold. The codes map to thresholds as 001=2, 010=8, 011=32, 100=64, 101=128, 110=256 and 111=512 ticks.
- R12: ret_req is 0 in any cycle in which cache_idle is 0, including the cycle in which idle falls.
- R13: When bits 2:0 are 000, ret_req is held at 0. Writing 000 while the request is high removes it in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_wdata | input | 32 | Write data |
| req_priv | input | 2 | Requester privilege level, 0 to 3 |
| req_ns | input | 1 | Requester is non-secure |
| el3_en | input | 1 | Write enable granted by level 3 |
| el2_en | input | 1 | Write enable granted by level 2 |
| ram_ecc_err | input | 1 | Uncorrectable RAM ECC error pulse |
| bus_err | input | 1 | External bus error pulse |
| timer_tick | input | 1 | Single-cycle system timer tick |
| cache_idle | input | 1 | Cache reports no activity |
| reg_rdata | output | 32 | Read data, combinational while a read is strobed |
| ret_req | output | 1 | RAM retention request |
| acc_fault | output | 1 | One-cycle pulse for a refused write |

## Verification
The bench builds the block with its default parameters: a 32-bit word, flags at bits 30 and 29, and a 10-bit idle counter. With ticks on every cycle, the deepest 512-tick threshold is reached in about 512 cycles. This makes every threshold code, and the counter's full range below saturation, reachable within a short run. Random traffic mixes all four privilege levels, both security states and every enable combination with error pulses and idle drops. Directed passes measure each threshold exactly and exercise the same-cycle set-versus-clear case.

// File: rtl/cache_ctl_pkg.sv
`timescale 1ns/1ps
package cache_ctl_pkg;

    // Width of the idle-threshold code held in the low bits of the word.
    localparam int unsigned CODE_W   = 3;
    // log2 of the largest threshold (code 111 selects 2**MAX_LOG2 ticks).
    localparam int unsigned MAX_LOG2 = (1 << CODE_W) + 1;
    // Counter is one bit wider than the largest threshold needs.
    localparam int unsigned CNT_W    = MAX_LOG2 + 1;

    typedef enum logic [1:0] {
        PRIV_USER = 2'd0,
        PRIV_OS   = 2'd1,
        PRIV_HYP  = 2'd2,
        PRIV_MON  = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        RS_BUSY   = 2'd0,
        RS_WAIT   = 2'd1,
        RS_RETAIN = 2'd2
    } ret_state_e;

endpackage

// File: rtl/cache_ctl_access.sv
`timescale 1ns/1ps
module cache_ctl_access
    import cache_ctl_pkg::*;
(
    input  logic       acc_en,
    input  logic       acc_wr,
    input  logic [1:0] priv,
    input  logic       nonsecure,
    input  logic       en_l3,
    input  logic       en_l2,
    output logic       rd_ok,
    output logic       wr_ok,
    output logic       wr_deny
);

    priv_e priv_lvl;
    logic  permit_wr;

    assign priv_lvl = priv_e'(priv);

    // Layered write permission; reads are denied only to the user level.
    always_comb begin
        rd_ok     = 1'b1;
        permit_wr = 1'b1;
        unique case (priv_lvl)
            PRIV_USER: begin
                rd_ok     = 1'b0;
                permit_wr = 1'b0;
            end
            PRIV_OS: begin
                // Non-secure needs both enables, secure needs only level 3.
                permit_wr = en_l3 & (en_l2 | ~nonsecure);
            end
            PRIV_HYP, PRIV_MON: begin
                permit_wr = 1'b1;
            end
            default: begin
                rd_ok     = 1'b0;
                permit_wr = 1'b0;
            end
        endcase
    end

    assign wr_ok   = acc_en & acc_wr &  permit_wr;
    assign wr_deny = acc_en & acc_wr & ~permit_wr;

endmodule

// File: rtl/cache_ctl_regs.sv
`timescale 1ns/1ps
module cache_ctl_regs
    import cache_ctl_pkg::*;
#(
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned RAM_FLAG_BIT = 30,
    parameter int unsigned BUS_FLAG_BIT = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic              wr_deny,
    input  logic              wr_ram_bit,
    input  logic              wr_bus_bit,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              ram_set,
    input  logic              bus_set,
    output logic [CODE_W-1:0] code_q,
    output logic              flag_ram_q,
    output logic              flag_bus_q,
    output logic              fault_q,
    output logic [DATA_W-1:0] word
);

    logic clr_ram, clr_bus;
    logic flag_ram_d, flag_bus_d;

    // A clearing write only lands when accepted; a set pulse always wins.
    assign clr_ram    = wr_ok & ~wr_ram_bit;
    assign clr_bus    = wr_ok & ~wr_bus_bit;
    assign flag_ram_d = ram_set | (flag_ram_q & ~clr_ram);
    assign flag_bus_d = bus_set | (flag_bus_q & ~clr_bus);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q     <= '0;
            flag_ram_q <= 1'b0;
            flag_bus_q <= 1'b0;
            fault_q    <= 1'b0;
        end else begin
            flag_ram_q <= flag_ram_d;
            flag_bus_q <= flag_bus_d;
            fault_q    <= wr_deny;
            if (wr_ok) begin
                code_q <= wr_code;
            end
        end
    end

    // Assemble the read word; every unlisted bit stays zero.
    always_comb begin
        word                  = '0;
        word[CODE_W-1:0]      = code_q;
        word[RAM_FLAG_BIT]    = flag_ram_q;
        word[BUS_FLAG_BIT]    = flag_bus_q;
    end

endmodule

// File: rtl/cache_ctl_idle.sv
`timescale 1ns/1ps
module cache_ctl_idle
    import cache_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic              tick,
    input  logic              idle,
    output logic              ret_req
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    ret_state_e         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [CNT_W-1:0]   thr;
    logic [3:0]         shamt;
    logic               enabled;
    logic               reached;

    assign enabled = (code != '0);

    // Threshold decode: 1->2, 2->8, otherwise 2**(code+2).
    always_comb begin
        unique case (code)
            3'd1:    shamt = 4'd1;
            3'd2:    shamt = 4'd3;
            default: shamt = {1'b0, code} + 4'd2;
        endcase
        thr = CNT_ONE << shamt;
    end

    // Idle tick counter: clears on activity, saturates at the top.
    always_comb begin
        if (!idle) begin
            cnt_d = '0;
        end else if (tick && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + CNT_ONE;
        end else begin
            cnt_d = cnt_q;
        end
    end

    assign reached = enabled & (cnt_d >= thr);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_BUSY: begin
                if (idle) state_d = RS_WAIT;
            end
            RS_WAIT: begin
                if (!idle)        state_d = RS_BUSY;
                else if (reached) state_d = RS_RETAIN;
            end
            RS_RETAIN: begin
                if (!idle)         state_d = RS_BUSY;
                else if (!reached) state_d = RS_WAIT;
            end
            default: state_d = RS_BUSY;
        endcase
    end

    // State register and counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_BUSY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output process: the request is gated by live idle and a live code.
    always_comb begin
        ret_req = 1'b0;
        unique case (state_q)
            RS_RETAIN: ret_req = idle & enabled;
            RS_BUSY, RS_WAIT: ret_req = 1'b0;
            default: ret_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/cache_ctl_top.sv
`timescale 1ns/1ps
module cache_ctl_top
    import cache_ctl_pkg::*;
#(
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned RAM_FLAG_BIT = 30,
    parameter int unsigned BUS_FLAG_BIT = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [1:0]        req_priv,
    input  logic              req_ns,
    input  logic              el3_en,
    input  logic              el2_en,
    input  logic              ram_ecc_err,
    input  logic              bus_err,
    input  logic              timer_tick,
    input  logic              cache_idle,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              ret_req,
    output logic              acc_fault
);

    logic              rd_ok, wr_ok, wr_deny;
    logic [CODE_W-1:0] code_q;
    logic              flag_ram_q, flag_bus_q;
    logic [DATA_W-1:0] word;
    logic              unused_wbits;

    // Reserved write bits carry no function.
    assign unused_wbits = ^{reg_wdata[DATA_W-1], reg_wdata[BUS_FLAG_BIT-1:CODE_W]};

    cache_ctl_access u_access (
        .acc_en    (reg_en),
        .acc_wr    (reg_wr),
        .priv      (req_priv),
        .nonsecure (req_ns),
        .en_l3     (el3_en),
        .en_l2     (el2_en),
        .rd_ok     (rd_ok),
        .wr_ok     (wr_ok),
        .wr_deny   (wr_deny)
    );

    cache_ctl_regs #(
        .DATA_W       (DATA_W),
        .RAM_FLAG_BIT (RAM_FLAG_BIT),
        .BUS_FLAG_BIT (BUS_FLAG_BIT)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ok      (wr_ok),
        .wr_deny    (wr_deny),
        .wr_ram_bit (reg_wdata[RAM_FLAG_BIT]),
        .wr_bus_bit (reg_wdata[BUS_FLAG_BIT]),
        .wr_code    (reg_wdata[CODE_W-1:0]),
        .ram_set    (ram_ecc_err),
        .bus_set    (bus_err),
        .code_q     (code_q),
        .flag_ram_q (flag_ram_q),
        .flag_bus_q (flag_bus_q),
        .fault_q    (acc_fault),
        .word       (word)
    );

    cache_ctl_idle u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .code    (code_q),
        .tick    (timer_tick),
        .idle    (cache_idle),
        .ret_req (ret_req)
    );

    assign reg_rdata = (reg_en && !reg_wr && rd_ok) ? word : '0;

endmodule

// File: rtl/cache_ctl_chk.sv
`timescale 1ns/1ps
module cache_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_en,
    input logic        reg_wr,
    input logic [1:0]  req_priv,
    input logic [31:0] reg_rdata,
    input logic        ram_ecc_err,
    input logic        bus_err,
    input logic        cache_idle,
    input logic        ret_req,
    input logic        acc_fault,
    input logic [2:0]  code,
    input logic        flag_ram,
    input logic        flag_bus
);

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[31] == 1'b0) && (reg_rdata[28:3] == '0));

    assert_ecc_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_ecc_err |=> flag_ram);

    assert_bus_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> flag_bus);

    assert_user_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_wr && req_priv == 2'd0) |-> (reg_rdata == '0));

    assert_fault_follows_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault |-> $past(reg_en && reg_wr));

    assert_fault_keeps_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault |-> (code == $past(code)));

    assert_req_needs_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ret_req |-> cache_idle);

    assert_req_off_when_disabled_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 3'd0) |-> !ret_req);

endmodule

bind cache_ctl_top cache_ctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_en      (reg_en),
    .reg_wr      (reg_wr),
    .req_priv    (req_priv),
    .reg_rdata   (reg_rdata),
    .ram_ecc_err (ram_ecc_err),
    .bus_err     (bus_err),
    .cache_idle  (cache_idle),
    .ret_req     (ret_req),
    .acc_fault   (acc_fault),
    .code        (code_q),
    .flag_ram    (flag_ram_q),
    .flag_bus    (flag_bus_q)
);

// File: tb/sim_cache_ctl_top.sv
`timescale 1ns/1ps
module sim_cache_ctl_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0, reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  req_priv = 2'd3;
    logic        req_ns = 1'b0, el3_en = 1'b0, el2_en = 1'b0;
    logic        ram_ecc_err = 1'b0, bus_err = 1'b0;
    logic        timer_tick = 1'b0, cache_idle = 1'b0;
    logic [31:0] reg_rdata;
    logic        ret_req, acc_fault;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // Reference model state, driven from the requirements.
    logic [2:0] m_code = '0;
    logic       m_fram = 0, m_fbus = 0, m_fault = 0, m_ret = 0;
    int         m_cnt = 0;

    always #4 clk = ~clk;   // 125 MHz

    cache_ctl_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .req_priv(req_priv), .req_ns(req_ns),
        .el3_en(el3_en), .el2_en(el2_en), .ram_ecc_err(ram_ecc_err),
        .bus_err(bus_err), .timer_tick(timer_tick), .cache_idle(cache_idle),
        .reg_rdata(reg_rdata), .ret_req(ret_req), .acc_fault(acc_fault)
    );

    // R7, R8, R9 permission rule.
    function automatic bit may_write(logic [1:0] p, logic ns, logic e3, logic e2);
        case (p)
            2'd0:    return 1'b0;
            2'd1:    return ns ? (e3 && e2) : e3;
            default: return 1'b1;
        endcase
    endfunction

    // R11 threshold table.
    function automatic int thr_of(logic [2:0] c);
        case (c)
            3'd1: return 2;    3'd2: return 8;   3'd3: return 32;
            3'd4: return 64;   3'd5: return 128; 3'd6: return 256;
            3'd7: return 512;  default: return 0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Model update at each edge, plus watchdog.
    always @(posedge clk) begin
        bit wok;
        int cn;
        cyc++;
        if (cyc == 150000 && !done) begin
            errors++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            finish_run();
        end
        if (!rst_n) begin
            m_code = '0; m_fram = 0; m_fbus = 0; m_fault = 0; m_ret = 0; m_cnt = 0;
        end else begin
            wok     = reg_en && reg_wr && may_write(req_priv, req_ns, el3_en, el2_en);
            m_fault = reg_en && reg_wr && !wok;
            if (!cache_idle)                      cn = 0;
            else if (timer_tick && m_cnt < 1023)  cn = m_cnt + 1;
            else                                  cn = m_cnt;
            m_ret  = cache_idle && (m_code != 0) && (cn >= thr_of(m_code));
            m_cnt  = cn;
            m_fram = ram_ecc_err | (m_fram & !(wok && !reg_wdata[30]));
            m_fbus = bus_err     | (m_fbus & !(wok && !reg_wdata[29]));
            if (wok) m_code = reg_wdata[2:0];
        end
    end

    // Continuous comparison against the model, away from the active edge.
    always @(negedge clk) begin
        logic [31:0] ew;
        #3;
        if (rst_n && !done) begin
            chk("R11/R12/R13 ret_req", {31'b0, ret_req},
                {31'b0, m_ret && cache_idle && (m_code != 0)});
            chk("R10 acc_fault", {31'b0, acc_fault}, {31'b0, m_fault});
            if (reg_en && !reg_wr) begin
                ew = (req_priv == 2'd0) ? 32'h0 : {1'b0, m_fram, m_fbus, 26'b0, m_code};
                if (req_priv == 2'd0) chk("R7 user read", reg_rdata, 32'h0);
                chk("R2 reserved", reg_rdata & 32'h9FFF_FFF8, 32'h0);
                chk("R3 ram flag", {31'b0, reg_rdata[30]}, {31'b0, ew[30]});
                chk("R4 bus flag", {31'b0, reg_rdata[29]}, {31'b0, ew[29]});
                chk("R6 code", {29'b0, reg_rdata[2:0]}, {29'b0, ew[2:0]});
            end
        end
    end

    task automatic wr(logic [1:0] p, logic ns, logic e3, logic e2, logic [31:0] d,
                      output logic fault);
        @(negedge clk); #1;
        reg_en = 1; reg_wr = 1; req_priv = p; req_ns = ns; el3_en = e3; el2_en = e2;
        reg_wdata = d;
        @(negedge clk); #1;
        fault = acc_fault;
        reg_en = 0; reg_wr = 0;
    endtask

    task automatic rd(logic [1:0] p, output logic [31:0] v);
        @(negedge clk); #1;
        reg_en = 1; reg_wr = 0; req_priv = p;
        #2 v = reg_rdata;
        @(negedge clk); #1;
        reg_en = 0;
    endtask

    initial begin
        logic [31:0] v;
        logic f;
        int n;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(2'd3, v);
        chk("R1 reset word", v, 32'h0);
        chk("R1 reset ret_req", {31'b0, ret_req}, 32'h0);
        chk("R1 reset acc_fault", {31'b0, acc_fault}, 32'h0);

        // R2 / R3 / R4: all ones write, flags ignore 1s
        wr(2'd3, 0, 0, 0, 32'hFFFF_FFFF, f);
        rd(2'd3, v);
        chk("R2 all-ones write readback", v, 32'h0000_0007);

        // R3: set, write 1 keeps, write 0 clears
        @(negedge clk); #1 ram_ecc_err = 1;
        @(negedge clk); #1 ram_ecc_err = 0;
        rd(2'd2, v);  chk("R3 flag set", {31'b0, v[30]}, 32'h1);
        wr(2'd2, 0, 0, 0, 32'h4000_0007, f);
        rd(2'd2, v);  chk("R3 write 1 ignored", {31'b0, v[30]}, 32'h1);
        wr(2'd2, 0, 0, 0, 32'h0000_0007, f);
        rd(2'd2, v);  chk("R3 write 0 clears", {31'b0, v[30]}, 32'h0);

        // R4 same rule for the bus flag
        @(negedge clk); #1 bus_err = 1;
        @(negedge clk); #1 bus_err = 0;
        rd(2'd3, v);  chk("R4 flag set", {31'b0, v[29]}, 32'h1);
        wr(2'd3, 0, 0, 0, 32'h2000_0007, f);
        rd(2'd3, v);  chk("R4 write 1 ignored", {31'b0, v[29]}, 32'h1);
        wr(2'd3, 0, 0, 0, 32'h0000_0007, f);
        rd(2'd3, v);  chk("R4 write 0 clears", {31'b0, v[29]}, 32'h0);

        // R5: set pulse and clearing write in the same cycle
        @(negedge clk); #1 ram_ecc_err = 1; bus_err = 1;
        @(negedge clk); #1 ram_ecc_err = 0; bus_err = 0;
        @(negedge clk); #1;
        reg_en = 1; reg_wr = 1; req_priv = 2'd3; reg_wdata = 32'h0000_0005;
        ram_ecc_err = 1; bus_err = 1;
        @(negedge clk); #1;
        reg_en = 0; reg_wr = 0; ram_ecc_err = 0; bus_err = 0;
        rd(2'd3, v);
        chk("R5 set beats clear", v, 32'h6000_0005);
        wr(2'd3, 0, 0, 0, 32'h0000_0005, f);

        // R7: user level
        wr(2'd0, 0, 1, 1, 32'h0000_0002, f);
        chk("R7 user write faults", {31'b0, f}, 32'h1);
        rd(2'd0, v);  chk("R7 user read zero", v, 32'h0);
        rd(2'd3, v);  chk("R7 user write dropped", v, 32'h0000_0005);

        // R8: privilege 1 rules
        wr(2'd1, 1, 1, 0, 32'h0000_0003, f);
        chk("R8 ns no l2 faults", {31'b0, f}, 32'h1);
        rd(2'd1, v);  chk("R10 refused keeps word", v, 32'h0000_0005);
        wr(2'd1, 1, 1, 1, 32'h0000_0003, f);
        chk("R8 ns both ok", {31'b0, f}, 32'h0);
        wr(2'd1, 0, 0, 1, 32'h0000_0004, f);
        chk("R8 secure no l3 faults", {31'b0, f}, 32'h1);
        wr(2'd1, 0, 1, 0, 32'h0000_0004, f);
        chk("R8 secure l3 ok", {31'b0, f}, 32'h0);
        rd(2'd1, v);  chk("R8 readback", v, 32'h0000_0004);

        // R9: levels 2 and 3 with no enables
        wr(2'd2, 1, 0, 0, 32'h0000_0001, f);
        chk("R9 level2 ok", {31'b0, f}, 32'h0);
        wr(2'd3, 1, 0, 0, 32'h0000_0006, f);
        chk("R9 level3 ok", {31'b0, f}, 32'h0);
        rd(2'd3, v);  chk("R6 readback", v, 32'h0000_0006);

        // R11: measure every threshold
        for (int c = 1; c < 8; c++) begin
            wr(2'd3, 0, 0, 0, 32'(c), f);
            @(negedge clk); #1 cache_idle = 0; timer_tick = 0;
            @(negedge clk); #1 cache_idle = 1; timer_tick = 1;
            n = 0;
            while (n < 600) begin
                @(negedge clk); #3;
                n++;
                if (ret_req) break;
            end
            chk($sformatf("R11 threshold code %0d", c), 32'(n), 32'(thr_of(3'(c))));
        end

        // R12: request drops in the cycle idle falls
        @(negedge clk); #1 cache_idle = 0;
        #1 chk("R12 same-cycle drop", {31'b0, ret_req}, 32'h0);
        @(negedge clk); #1 cache_idle = 1;

        // R13: rewrite to 000 and back while idle
        wr(2'd3, 0, 0, 0, 32'h0000_0001, f);
        repeat (4) @(negedge clk);
        #3 chk("R13 retaining at code 1", {31'b0, ret_req}, 32'h1);
        wr(2'd3, 0, 0, 0, 32'h0000_0000, f);
        #2 chk("R13 code 000 holds low", {31'b0, ret_req}, 32'h0);
        wr(2'd3, 0, 0, 0, 32'h0000_0001, f);
        @(negedge clk); #3;
        chk("R13 new code takes effect", {31'b0, ret_req}, 32'h1);

        // Constrained random traffic
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk); #1;
            reg_en      = ($urandom % 6) == 0;
            reg_wr      = $urandom % 2;
            reg_wdata   = $urandom;
            if (($urandom % 4) != 0) reg_wdata[2:0] = 3'($urandom % 3 + 1);
            req_priv    = 2'($urandom);
            req_ns      = $urandom % 2;
            el3_en      = $urandom % 2;
            el2_en      = $urandom % 2;
            ram_ecc_err = ($urandom % 40) == 0;
            bus_err     = ($urandom % 40) == 0;
            timer_tick  = $urandom % 2;
            cache_idle  = (i % 1000 < 500) ? (($urandom % 64) != 0) : (($urandom % 8) != 0);
        end
        @(negedge clk); #1;
        reg_en = 0; ram_ecc_err = 0; bus_err = 0;
        repeat (2) @(negedge clk);
        #4 finish_run();
    end

endmodule